// File: doc/BRIEF.md
# DMA Channel Priority Arbiter

This block decides which of seven DMA channels owns the shared bus next. Each channel has three inputs. One is a request line. One is an enable bit. The third is a two-bit priority field set by software. The arbiter presents one owner at a time as a one-hot grant vector with a separate valid flag. The grant stays with that channel until the channel signals that its transfer has finished.

The choice of the next owner is made early. A candidate register is updated every cycle from the latched requests while the current owner is still moving data. When the owner finishes, the candidate moves into the grant at the same clock edge, so waiting work starts with no idle cycle.

The arbiter also controls how much of the bus the DMA may use. Time is divided into frames of five cycles counted from reset. A beat-permission output allows at most two DMA data beats in each frame, which leaves the other cycles free for a CPU master. A channel moves data only in cycles where beat permission is high, and it must drop its request in the cycle it signals completion.

Top module: `dma_arbiter`

## Requirements
- R1: While the synchronous active-low reset is low, and in the first cycle after it, `grant` is all zeros and both `grant_valid` and `beat_ok` are 0.
- R2: Bit i of `grant` stands for channel i (0 to 6). Whenever `grant_valid` is 1, exactly one bit of `grant` is set. Whenever `grant_valid` is 0, `grant` is all zeros.
- R3: The priority of channel i is `ch_prio[2*i+1:2*i]`. The code 2'b11 is the highest level, then 2'b10, then 2'b01, and 2'b00 is the lowest. The next grant goes to a requesting channel at the highest level present.
- R4: When several requesting channels share that highest level, the one with the smallest index wins.
- R5: A channel whose `ch_en` bit is 0 is never granted, even while its `ch_req` bit is 1.
- R6: A grant does not change until `xfer_done` is high in a cycle where `beat_ok` is also high. A `xfer_done` pulse in a cycle where `beat_ok` is low is ignored.
- R7: The new owner is loaded at the same edge that samples an accepted done. If another enabled request has been present for at least two cycles, `grant_valid` is therefore high again in the very next cycle.
- R8: The channel that held the grant when a done was accepted is not the next owner, even if its request is still high.
- R9: `beat_ok` is high only while `grant_valid` is high. It is high in at most 2 of the 5 cycles of each frame, and frames are counted from the first cycle after reset.
- R10: When the arbiter is idle, a request raised before clock edge k produces `grant_valid` from edge k+2 onward. The request is latched at edge k, the candidate is computed at edge k+1, and the grant is loaded at edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ch_req | input | 7 | Request line for each channel |
| ch_en | input | 7 | Enable bit for each channel |
| ch_prio | input | 14 | Two-bit priority for each channel; channel i uses bits [2i+1:2i] |
| xfer_done | input | 1 | One-cycle completion strobe from the owning channel |
| grant | output | 7 | One-hot owner of the bus |
| grant_valid | output | 1 | The grant vector is valid |
| beat_ok | output | 1 | The owner may drive a data beat in this cycle |

## Verification
If the candidate register holds a wrong value, the wrong channel appears on `grant` at the first accepted done. The scoreboard, which keeps the service order in priority-then-index order, reports this on that beat. If the mask misses the owner, the same channel is served twice in a row, and this shows one cycle after its done. If the frame or budget counter is wrong, a frame carries more than two beats or never reaches two, and this is seen at the end of a five-cycle frame. A done accepted with `beat_ok` low, or a lost grant, shows in the cycle right after the strobe.

// File: rtl/dma_arb_pkg.sv
// Package dma_arb_pkg
// Shared constants for the DMA channel arbiter.
// Assumes a two-bit priority field where a larger value means more urgent.
package dma_arb_pkg;
    localparam int PRIO_W = 2;
    typedef logic [PRIO_W-1:0] prio_t;
    localparam prio_t PRIO_TOP    = 2'b11;
    localparam prio_t PRIO_UPPER  = 2'b10;
    localparam prio_t PRIO_LOWER  = 2'b01;
    localparam prio_t PRIO_BOTTOM = 2'b00;
endpackage

// File: rtl/dma_arb_req_latch.sv
// Module dma_arb_req_latch
// Registers the channel requests, qualified by their enable bits, once per cycle.
// Assumes a channel holds its request until it is served.
module dma_arb_req_latch #(
    parameter int NUM_CH = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ch_req,
    input  logic [NUM_CH-1:0] ch_en,
    output logic [NUM_CH-1:0] req_q
);
    // Capture the enabled requests; disabled channels never reach arbitration.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= ch_req & ch_en;
    end
endmodule

// File: rtl/dma_arb_pick.sv
// Module dma_arb_pick
// Chooses the winner among the latched, unmasked requests and registers it
// as the candidate for the next grant. A higher level wins; on equal
// levels the lower index wins. Assumes the mask covers the channels that
// own, or are about to own, the bus.
module dma_arb_pick
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        req_q,
    input  logic [NUM_CH*PRIO_W-1:0] prio_flat,
    input  logic [NUM_CH-1:0]        mask,
    output logic [NUM_CH-1:0]        cand,
    output logic                     cand_valid
);
    prio_t             lvl [NUM_CH];
    logic [NUM_CH-1:0] elig;
    logic [NUM_CH-1:0] best_oh;
    logic              best_found;
    prio_t             best_lvl;

    // Unpack the per-channel priority fields.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_unpack
        assign lvl[g] = prio_flat[g*PRIO_W +: PRIO_W];
    end

    assign elig = req_q & ~mask;

    // Ascending scan; a strict compare keeps the lowest index on ties.
    always_comb begin
        best_found = 1'b0;
        best_lvl   = PRIO_BOTTOM;
        best_oh    = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (elig[i] && (!best_found || lvl[i] > best_lvl)) begin
                best_found = 1'b1;
                best_lvl   = lvl[i];
                best_oh    = '0;
                best_oh[i] = 1'b1;
            end
        end
    end

    // Register the decision so it is ready before the bus frees up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand       <= '0;
            cand_valid <= 1'b0;
        end else begin
            cand       <= best_oh;
            cand_valid <= best_found;
        end
    end

    AST_CAND_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid |-> $onehot(cand)); // R2
    AST_CAND_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !cand_valid |-> (cand == '0)); // R2
endmodule

// File: rtl/dma_arb_slot_gov.sv
// Module dma_arb_slot_gov
// Splits time into frames of FRAME_LEN cycles, starting at reset, and
// allows at most DMA_MAX DMA beats in each frame. Assumes the owner moves
// data only when beat_ok is high.
module dma_arb_slot_gov #(
    parameter int FRAME_LEN = 5,
    parameter int DMA_MAX   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic grant_valid,
    output logic beat_ok
);
    localparam int FW = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
    localparam int UW = $clog2(DMA_MAX + 1);
    localparam logic [FW-1:0] LAST = FW'(FRAME_LEN - 1);

    logic [FW-1:0] fcnt_q;
    logic [UW-1:0] used_q;

    assign beat_ok = grant_valid && (used_q < UW'(DMA_MAX));

    // Advance the frame position and count the beats used in this frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcnt_q <= '0;
            used_q <= '0;
        end else if (fcnt_q == LAST) begin
            fcnt_q <= '0;
            used_q <= '0;
        end else begin
            fcnt_q <= fcnt_q + FW'(1);
            used_q <= used_q + UW'(beat_ok);
        end
    end

    AST_FRAME_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        (fcnt_q == '0) |-> (used_q == '0)); // R9
    AST_BUDGET_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        used_q <= UW'(DMA_MAX)); // R9
endmodule

// File: rtl/dma_arbiter.sv
// Module dma_arbiter (top)
// Priority arbiter for NUM_CH DMA channels with a pipelined next-owner
// decision and a cap on the DMA share of bus cycles.
// Assumes the owner raises xfer_done for one cycle with its final beat
// and drops its request in that same cycle.
module dma_arbiter
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH    = 7,
    parameter int FRAME_LEN = 5,
    parameter int DMA_MAX   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        ch_req,
    input  logic [NUM_CH-1:0]        ch_en,
    input  logic [NUM_CH*PRIO_W-1:0] ch_prio,
    input  logic                     xfer_done,
    output logic [NUM_CH-1:0]        grant,
    output logic                     grant_valid,
    output logic                     beat_ok
);
    logic [NUM_CH-1:0] req_q;
    logic [NUM_CH-1:0] cand;
    logic              cand_valid;
    logic [NUM_CH-1:0] grant_q;
    logic              gvalid_q;
    logic [NUM_CH-1:0] grant_next;
    logic              gvalid_next;
    logic [NUM_CH-1:0] pick_mask;
    logic              accept;

    dma_arb_req_latch #(.NUM_CH(NUM_CH)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .ch_req (ch_req),
        .ch_en  (ch_en),
        .req_q  (req_q)
    );

    dma_arb_pick #(.NUM_CH(NUM_CH)) u_pick (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_q      (req_q),
        .prio_flat  (ch_prio),
        .mask       (pick_mask),
        .cand       (cand),
        .cand_valid (cand_valid)
    );

    dma_arb_slot_gov #(.FRAME_LEN(FRAME_LEN), .DMA_MAX(DMA_MAX)) u_gov (
        .clk         (clk),
        .rst_n       (rst_n),
        .grant_valid (gvalid_q),
        .beat_ok     (beat_ok)
    );

    assign accept = xfer_done && beat_ok;

    // Hand over to the candidate when idle or when the owner's done is accepted.
    always_comb begin
        grant_next  = grant_q;
        gvalid_next = gvalid_q;
        if (!gvalid_q || accept) begin
            grant_next  = cand_valid ? cand : '0;
            gvalid_next = cand_valid;
        end
    end

    // Keep both the present owner and the incoming owner out of the next pick.
    assign pick_mask = grant_q | grant_next;

    // Grant register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q  <= '0;
            gvalid_q <= 1'b0;
        end else begin
            grant_q  <= grant_next;
            gvalid_q <= gvalid_next;
        end
    end

    assign grant       = grant_q;
    assign grant_valid = gvalid_q;

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> $onehot(grant)); // R2
    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_valid |-> (grant == '0)); // R2
    AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !(xfer_done && beat_ok)) |=> (grant_valid && grant == $past(grant))); // R6
    AST_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && xfer_done && beat_ok) |=> ((grant & $past(grant)) == '0)); // R8
    AST_BEAT_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        beat_ok |-> grant_valid); // R9
endmodule

// File: tb/dma_arbiter_test.sv
`timescale 1ns/1ps
module dma_arbiter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  ch_req = '0;
    logic [6:0]  ch_en = '0;
    logic [13:0] ch_prio = '0;
    logic        xfer_done = 1'b0;
    logic [6:0]  grant;
    logic        grant_valid;
    logic        beat_ok;

    int    errors = 0;
    int    checks = 0;
    int    exp_q[$];
    bit    auto_resp = 1'b0;
    bit    expect_busy = 1'b0;
    bit    saw_full = 1'b0;
    bit    finished = 1'b0;
    int    pos = 0;
    int    frame_beats = 0;
    string cur_tag = "R3";

    always #2.5 clk = ~clk;

    dma_arbiter uut (
        .clk(clk), .rst_n(rst_n), .ch_req(ch_req), .ch_en(ch_en),
        .ch_prio(ch_prio), .xfer_done(xfer_done), .grant(grant),
        .grant_valid(grant_valid), .beat_ok(beat_ok)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int idx_of(input logic [6:0] g);
        int r = -1;
        for (int i = 0; i < 7; i++) if (g[i]) r = i;
        return r;
    endfunction

    // Count clock edges since reset release; this gives the frame position.
    always @(posedge clk) begin
        if (!rst_n) pos <= 0;
        else        pos <= pos + 1;
    end

    // Monitor and responder: pop the expected owner on each served beat.
    always @(negedge clk) begin
        if (!rst_n) begin
            frame_beats = 0;
        end else begin
            if (expect_busy) begin
                check(grant_valid, "R7", "grant in cycle after done", grant_valid, 1);
                expect_busy = 1'b0;
            end
            if (beat_ok) frame_beats++;
            if (pos % 5 == 4) begin
                check(frame_beats <= 2, "R9", "beats in frame", frame_beats, 2);
                if (frame_beats == 2) saw_full = 1'b1;
                frame_beats = 0;
            end
            if (auto_resp) begin
                xfer_done = 1'b0;
                if (grant_valid && beat_ok) begin
                    int idx;
                    idx = idx_of(grant);
                    check($countones(grant) == 1, "R2", "one-hot grant", $countones(grant), 1);
                    if (exp_q.size() == 0) begin
                        check(1'b0, cur_tag, "unexpected owner", idx, -1);
                    end else begin
                        int e;
                        e = exp_q.pop_front();
                        check(idx == e, cur_tag, "service order", idx, e);
                    end
                    xfer_done = 1'b1;
                    if (idx >= 0) ch_req[idx] = 1'b0;
                    if (exp_q.size() > 0) expect_busy = 1'b1;
                end
            end
        end
    end

    // Driver: apply a request pattern and queue the expected service order.
    task automatic run_pattern(input logic [6:0] en, input logic [13:0] pr,
                               input logic [6:0] rq, input string tag);
        cur_tag = tag;
        for (int lv = 3; lv >= 0; lv--)
            for (int i = 0; i < 7; i++)
                if (en[i] && rq[i] && pr[2*i +: 2] == 2'(lv)) exp_q.push_back(i);
        @(negedge clk);
        ch_en = en;
        ch_prio = pr;
        ch_req = rq;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (exp_q.size() == 0 && !grant_valid) break;
        end
        check(exp_q.size() == 0, tag, "pending owners after drain", exp_q.size(), 0);
        repeat (3) @(negedge clk);
        check(!grant_valid, "R5", "idle with only disabled requests", grant_valid, 0);
        ch_req = '0;
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_beat(input bit want);
        for (int k = 0; k < 20; k++) begin
            if (beat_ok == want) break;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(grant == '0 && !grant_valid && !beat_ok, "R1", "reset state",
              {grant_valid, beat_ok}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!grant_valid && !beat_ok, "R1", "first cycle after reset",
              {grant_valid, beat_ok}, 0);

        auto_resp = 1'b1;
        // Mixed levels: 2,5 (top), 3, 1,6, 0,4
        run_pattern(7'h7F, {2'b01, 2'b11, 2'b00, 2'b10, 2'b11, 2'b01, 2'b00}, 7'h7F, "R3");
        // Every channel at the top level: index order
        run_pattern(7'h7F, {7{2'b11}}, 7'h7F, "R4");
        // Only even channels enabled; channel 6 is most urgent
        run_pattern(7'b1010101, {2'b11, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01}, 7'h7F, "R5");
        auto_resp = 1'b0;
        xfer_done = 1'b0;

        // Request-to-grant latency while idle
        ch_en = 7'h7F;
        ch_prio = '0;
        ch_req = 7'b0000100;
        @(negedge clk);
        check(!grant_valid, "R10", "no grant after one edge", grant_valid, 0);
        @(negedge clk);
        check(!grant_valid, "R10", "no grant after two edges", grant_valid, 0);
        @(negedge clk);
        check(grant_valid && grant == 7'b0000100, "R10", "grant after three edges", grant, 4);

        // Done while the beat budget is spent is ignored
        wait_beat(1'b0);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        check(grant_valid && grant == 7'b0000100, "R6", "grant kept after unaccepted done", grant, 4);
        wait_beat(1'b1);
        xfer_done = 1'b1;
        ch_req = '0;
        @(negedge clk);
        xfer_done = 1'b0;
        check(!grant_valid, "R6", "grant released after accepted done", grant_valid, 0);
        repeat (4) @(negedge clk);

        // Owner keeps requesting; the next grant must still go elsewhere
        ch_prio = {2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b11, 2'b00};
        ch_req = 7'b0010010;
        for (int k = 0; k < 10; k++) begin
            if (grant_valid) break;
            @(negedge clk);
        end
        check(grant == 7'b0000010, "R3", "top level channel first", grant, 2);
        wait_beat(1'b1);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        check(grant_valid && grant == 7'b0010000, "R8", "former owner skipped", grant, 16);

        // Reset in the middle of a grant
        rst_n = 1'b0;
        ch_req = '0;
        @(negedge clk);
        check(grant == '0 && !grant_valid && !beat_ok, "R1", "reset clears grant",
              grant, 0);
        rst_n = 1'b1;
        @(negedge clk);

        check(saw_full, "R9", "a frame reached the two-beat share", saw_full, 1);
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule